// File: doc/BRIEF.md
# Frame-Based Thread Scheduler

This block sequences fine-grained threads on one processor. Threads are grouped into frames. Each frame holds a private LIFO of pending thread start addresses. Above the frames sits a FIFO of frames that have work waiting. The running code pushes new work onto the current frame with a fork request. It asks for the next address to run with a stop request. Message handlers deposit threads into any frame by identifier with a post request. When the current frame has nothing left, a swap request selects the next runnable frame and delivers its entry address.

When a frame is activated, its stack is seeded with a single bottom entry: the frame's exit routine address. Popping that entry tells the processor that the frame has run out of work and that it should swap. The block only tracks addresses and frame numbers. It does not execute instructions, save registers or allocate frame memory.

Every response (next address, frame-done, swap result, idle) is combinational in the request cycle. All state changes take effect at the following rising clock edge.

Top module: `frame_thread_sched`

## Requirements
- R1: After reset there is no current frame (cur_valid_o=0), the runnable queue is empty and overflow_o=0. A stop yields next_valid_o=0, and a swap yields idle_o=1.
- R2: An activate request writes the given exit address as the only entry (depth 1) of the named frame's stack. That exit address is the last address the frame's stops return.
- R3: A fork pushes fork_addr_i onto the current frame's stack. A stop returns the top entry on next_addr_o with next_valid_o=1 in the same cycle and removes it, in last-in first-out order. A stop on an empty current stack gives next_valid_o=0.
- R4: A fork and a stop in the same cycle return fork_addr_i on next_addr_o with next_valid_o=1, and leave the stack unchanged.
- R5: frame_done_o is 1 exactly when a stop (without fork) removes the last entry of the current stack, which is the exit entry.
- R6: A post pushes post_addr_i onto frame post_fid_i. If that frame is neither queued nor running, it is appended to the runnable queue. A post to a frame that is already queued does not add it again, so frames leave the queue in the order of their first post.
- R7: A post to the running frame pushes onto its stack and does not enter the queue.
- R8: A swap is accepted only when there is no current frame or the current stack is empty. Otherwise swap_valid_o=0 and idle_o=0, and the current frame is unchanged.
- R9: An accepted swap with a non-empty queue sets swap_valid_o=1 and gives the head frame on swap_fid_o and its top entry on swap_addr_o. It removes that entry, removes the frame from the queue and makes it current.
- R10: An accepted swap with an empty queue sets idle_o=1 and leaves cur_valid_o and cur_fid_o unchanged.
- R11: A push (fork or post) to a stack holding STACK_DEPTH entries is dropped and sets overflow_o. overflow_o stays set until reset. A fork is pushed before a post in the same cycle.
- R12: Fork and stop have no effect, and give next_valid_o=0, while swap_req_i is high or no frame is current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| act_valid_i | input | 1 | Activate (seed) a frame stack |
| act_fid_i | input | FID_W | Frame to activate |
| act_exit_addr_i | input | ADDR_W | Exit routine address for the seed entry |
| fork_valid_i | input | 1 | Push onto current frame |
| fork_addr_i | input | ADDR_W | Thread address to fork |
| stop_valid_i | input | 1 | Request next thread of current frame |
| next_valid_o | output | 1 | next_addr_o holds an address to run |
| next_addr_o | output | ADDR_W | Next thread address |
| frame_done_o | output | 1 | Exit entry was just popped |
| post_valid_i | input | 1 | Inlet post |
| post_fid_i | input | FID_W | Target frame of the post |
| post_addr_i | input | ADDR_W | Thread address posted |
| swap_req_i | input | 1 | Request a frame change |
| swap_valid_o | output | 1 | Swap taken |
| swap_fid_o | output | FID_W | Newly selected frame |
| swap_addr_o | output | ADDR_W | Entry thread address of that frame |
| idle_o | output | 1 | Swap found no runnable frame |
| cur_valid_o | output | 1 | A frame is current |
| cur_fid_o | output | FID_W | Current frame |
| overflow_o | output | 1 | Sticky stack overflow flag |

## Verification
On every cycle, the assertions check the following: the overflow flag never clears, the current frame changes only through a taken swap, an idle swap holds the frame, a busy frame is never swapped away, and the runnable queue never gains more entries than there are frames. Stack depth stays bounded. The following can only be shown by the bench's reference model, which is compared on every clock: the LIFO order, the fork-stop bypass, the single enqueue on first post, the FIFO order of frames, the exit-entry detection and the ordering of simultaneous fork and post pushes.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int unsigned DEF_NUM_FRAMES  = 8;
  localparam int unsigned DEF_STACK_DEPTH = 16;
  localparam int unsigned DEF_ADDR_W      = 16;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tfs_frame_stack.sv
module tfs_frame_stack #(
  parameter int unsigned DEPTH  = tfs_pkg::DEF_STACK_DEPTH,
  parameter int unsigned ADDR_W = tfs_pkg::DEF_ADDR_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = tfs_pkg::idx_w(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_i,
  input  logic [ADDR_W-1:0] seed_addr_i,
  input  logic              push0_i,
  input  logic [ADDR_W-1:0] push0_addr_i,
  input  logic              push1_i,
  input  logic [ADDR_W-1:0] push1_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] top_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, base, idx1, tidx;
  logic              do_pop, ok0, ok1, wr0, wr1;

  always_comb begin
    do_pop = pop_i && (cnt_q != '0);
    base   = cnt_q - CNT_W'(do_pop);
    ok0    = base < CNT_W'(DEPTH);
    wr0    = push0_i && ok0;
    idx1   = base + CNT_W'(wr0);
    ok1    = idx1 < CNT_W'(DEPTH);
    wr1    = push1_i && ok1;
    ovf_o  = !seed_i && ((push0_i && !ok0) || (push1_i && !ok1));
    tidx   = cnt_q - CNT_W'(1);
    top_o  = (cnt_q == '0) ? '0 : mem_q[tidx[IDX_W-1:0]];
  end

  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (seed_i) cnt_q <= CNT_W'(1);
    else             cnt_q <= idx1 + CNT_W'(wr1);
  end

  always_ff @(posedge clk_i) begin
    if (seed_i) begin
      mem_q[0] <= seed_addr_i;
    end else begin
      if (wr0) mem_q[base[IDX_W-1:0]] <= push0_addr_i;
      if (wr1) mem_q[idx1[IDX_W-1:0]] <= push1_addr_i;
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R11
endmodule

// File: rtl/tfs_ready_fifo.sv
module tfs_ready_fifo #(
  parameter int unsigned DEPTH = tfs_pkg::DEF_NUM_FRAMES,
  parameter int unsigned W     = 3,
  localparam int unsigned PTR_W = tfs_pkg::idx_w(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  AST_RUNQ_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full); // R6
  AST_RUNQ_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R9
endmodule

// File: rtl/frame_thread_sched.sv
module frame_thread_sched #(
  parameter int unsigned NUM_FRAMES  = tfs_pkg::DEF_NUM_FRAMES,
  parameter int unsigned STACK_DEPTH = tfs_pkg::DEF_STACK_DEPTH,
  parameter int unsigned ADDR_W      = tfs_pkg::DEF_ADDR_W,
  localparam int unsigned FID_W = tfs_pkg::idx_w(NUM_FRAMES),
  localparam int unsigned CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_valid_i,
  input  logic [FID_W-1:0]  act_fid_i,
  input  logic [ADDR_W-1:0] act_exit_addr_i,
  input  logic              fork_valid_i,
  input  logic [ADDR_W-1:0] fork_addr_i,
  input  logic              stop_valid_i,
  output logic              next_valid_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic              frame_done_o,
  input  logic              post_valid_i,
  input  logic [FID_W-1:0]  post_fid_i,
  input  logic [ADDR_W-1:0] post_addr_i,
  input  logic              swap_req_i,
  output logic              swap_valid_o,
  output logic [FID_W-1:0]  swap_fid_o,
  output logic [ADDR_W-1:0] swap_addr_o,
  output logic              idle_o,
  output logic              cur_valid_o,
  output logic [FID_W-1:0]  cur_fid_o,
  output logic              overflow_o
);
  logic [ADDR_W-1:0]     top_w [NUM_FRAMES];
  logic [CNT_W-1:0]      cnt_w [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] ovf_w, seed, push0, push1, pop;
  logic [NUM_FRAMES-1:0] queued_q;
  logic [FID_W-1:0]      cur_fid_q, head_fid;
  logic                  cur_valid_q, overflow_q, rq_empty;
  logic [CNT_W-1:0]      cur_cnt;
  logic                  swap_go, swap_take, fs_en, fork_go, stop_go;
  logic                  fork_push, stop_pop, running_post, enq;

  always_comb begin
    cur_cnt      = cnt_w[cur_fid_q];
    swap_go      = swap_req_i && (!cur_valid_q || cur_cnt == '0);
    swap_take    = swap_go && !rq_empty;
    fs_en        = cur_valid_q && !swap_req_i;
    fork_go      = fs_en && fork_valid_i;
    stop_go      = fs_en && stop_valid_i;
    fork_push    = fork_go && !stop_go;
    stop_pop     = stop_go && !fork_go && cur_cnt != '0;
    running_post = cur_valid_q && !swap_take && post_fid_i == cur_fid_q;
    enq          = post_valid_i && !queued_q[post_fid_i] && !running_post;
  end

  assign next_valid_o = stop_go && (fork_go || cur_cnt != '0);
  assign next_addr_o  = !next_valid_o ? '0 : fork_go ? fork_addr_i : top_w[cur_fid_q];
  assign frame_done_o = stop_go && !fork_go && cur_cnt == CNT_W'(1);
  assign swap_valid_o = swap_take;
  assign swap_fid_o   = swap_take ? head_fid : '0;
  assign swap_addr_o  = swap_take ? top_w[head_fid] : '0;
  assign idle_o       = swap_go && rq_empty;
  assign cur_valid_o  = cur_valid_q;
  assign cur_fid_o    = cur_fid_q;
  assign overflow_o   = overflow_q;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    localparam logic [FID_W-1:0] MY_FID = FID_W'(g);
    assign seed[g]  = act_valid_i && act_fid_i == MY_FID;
    assign push0[g] = fork_push && cur_fid_q == MY_FID;
    assign push1[g] = post_valid_i && post_fid_i == MY_FID;
    assign pop[g]   = (stop_pop && cur_fid_q == MY_FID) || (swap_take && head_fid == MY_FID);

    tfs_frame_stack #(.DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)) u_stack (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .seed_i       (seed[g]),
      .seed_addr_i  (act_exit_addr_i),
      .push0_i      (push0[g]),
      .push0_addr_i (fork_addr_i),
      .push1_i      (push1[g]),
      .push1_addr_i (post_addr_i),
      .pop_i        (pop[g]),
      .top_o        (top_w[g]),
      .cnt_o        (cnt_w[g]),
      .ovf_o        (ovf_w[g])
    );
  end

  tfs_ready_fifo #(.DEPTH(NUM_FRAMES), .W(FID_W)) u_runq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (enq),
    .push_data_i (post_fid_i),
    .pop_i       (swap_take),
    .head_o      (head_fid),
    .empty_o     (rq_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_valid_q <= 1'b0;
      cur_fid_q   <= '0;
      overflow_q  <= 1'b0;
      queued_q    <= '0;
    end else begin
      overflow_q <= overflow_q || (ovf_w != '0);
      if (swap_take) begin
        cur_valid_q        <= 1'b1;
        cur_fid_q          <= head_fid;
        queued_q[head_fid] <= 1'b0;
      end
      if (enq) queued_q[post_fid_i] <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_q |=> overflow_q); // R11
  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_valid_o |=> $stable(cur_fid_q) && $stable(cur_valid_q)); // R9
  AST_BUSY_NO_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid_q && cur_cnt != '0) |=> $stable(cur_fid_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> $stable(cur_fid_q) && $stable(cur_valid_q)); // R10
  AST_SWAP_IDLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(swap_valid_o && idle_o)); // R10
  AST_QUIET_ON_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_req_i |-> !next_valid_o && !frame_done_o); // R12
endmodule

// File: tb/tb_frame_thread_sched.sv
`timescale 1ns/1ps
module tb_frame_thread_sched;
  localparam int NF = 8;
  localparam int SD = 16;
  localparam int AW = 16;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          act_v = 0, fork_v = 0, stop_v = 0, post_v = 0, swap_r = 0;
  logic [FW-1:0] act_f = 0, post_f = 0;
  logic [AW-1:0] act_a = 0, fork_a = 0, post_a = 0;
  logic          next_v, done, swap_v, idle, cur_v, ovf;
  logic [AW-1:0] next_a, swap_a;
  logic [FW-1:0] swap_f, cur_f;

  frame_thread_sched dut (
    .clk_i(clk), .rst_ni(rst_n),
    .act_valid_i(act_v), .act_fid_i(act_f), .act_exit_addr_i(act_a),
    .fork_valid_i(fork_v), .fork_addr_i(fork_a), .stop_valid_i(stop_v),
    .next_valid_o(next_v), .next_addr_o(next_a), .frame_done_o(done),
    .post_valid_i(post_v), .post_fid_i(post_f), .post_addr_i(post_a),
    .swap_req_i(swap_r), .swap_valid_o(swap_v), .swap_fid_o(swap_f),
    .swap_addr_o(swap_a), .idle_o(idle), .cur_valid_o(cur_v),
    .cur_fid_o(cur_f), .overflow_o(ovf)
  );

  // behavioural reference
  int stk[NF][$];
  int rq[$];
  bit qd[NF];
  int cf;
  bit cv, movf;

  int n_cmp = 0, n_bad = 0;
  string ctx = "reset";
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  task automatic mpush(int f, int a);
    if (stk[f].size() < SD) stk[f].push_back(a);
    else movf = 1;
  endtask

  task automatic cyc();
    bit sw_go, fs_en, e_nv, e_done, e_sv, e_idle;
    int ccnt, e_na, hd;
    #1;
    ccnt  = cv ? stk[cf].size() : 0;
    sw_go = swap_r && (!cv || ccnt == 0);
    fs_en = cv && !swap_r;
    e_nv  = fs_en && stop_v && (fork_v || ccnt > 0);
    e_na  = !e_nv ? 0 : fork_v ? int'(fork_a) : stk[cf][$];
    e_done = fs_en && stop_v && !fork_v && ccnt == 1;
    e_sv  = sw_go && rq.size() > 0;
    e_idle = sw_go && rq.size() == 0;
    hd    = e_sv ? rq[0] : 0;
    chk(fork_v && stop_v ? "R4" : "R3", next_v, e_nv);
    if (e_nv) chk(fork_v && stop_v ? "R4" : "R3", next_a, e_na);
    chk("R5", done, e_done);
    chk("R8", swap_v, e_sv);
    chk("R10", idle, e_idle);
    if (e_sv) begin
      chk("R9", swap_f, hd);
      chk("R9", swap_a, stk[hd].size() > 0 ? stk[hd][$] : 0);
    end
    chk("R11", ovf, movf);
    chk("R1", cur_v, cv);
    if (cv) chk("R9", cur_f, cf);
    // model update
    if (fs_en && stop_v && !fork_v && ccnt > 0) void'(stk[cf].pop_back());
    if (e_sv && stk[hd].size() > 0) void'(stk[hd].pop_back());
    if (fs_en && fork_v && !stop_v) mpush(cf, fork_a);
    if (post_v) begin
      mpush(post_f, post_a);
      if (!qd[post_f] && !(cv && !e_sv && int'(post_f) == cf)) begin
        rq.push_back(post_f);
        qd[post_f] = 1;
      end
    end
    if (e_sv) begin
      void'(rq.pop_front());
      qd[hd] = 0;
      cf = hd;
      cv = 1;
    end
    if (act_v) begin
      stk[act_f].delete();
      stk[act_f].push_back(act_a);
    end
    @(negedge clk);
    act_v = 0; fork_v = 0; stop_v = 0; post_v = 0; swap_r = 0;
  endtask

  task automatic do_act(int f, int a);  act_v = 1; act_f = FW'(f); act_a = AW'(a); cyc(); endtask
  task automatic do_post(int f, int a); post_v = 1; post_f = FW'(f); post_a = AW'(a); cyc(); endtask
  task automatic do_fork(int a);        fork_v = 1; fork_a = AW'(a); cyc(); endtask
  task automatic do_stop();             stop_v = 1; cyc(); endtask
  task automatic do_swap();             swap_r = 1; cyc(); endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog [%s] actual=running expected=done", ctx);
    summary();
  end

  initial begin
    cv = 0; cf = 0; movf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ctx = "R1 reset state";
    do_stop();
    do_swap();                         // R10 idle with empty queue
    ctx = "R12 fork with no frame";
    do_fork(16'h0AAA);
    ctx = "R2 activate";
    for (int f = 0; f < 4; f++) do_act(f, 16'hE000 + f);
    ctx = "R6 first post enqueues once";
    do_post(2, 16'h0200);
    do_post(1, 16'h0100);
    do_post(2, 16'h0201);
    do_swap();                         // frame 2, entry 0201
    ctx = "R3 fork/stop";
    do_fork(16'h0300);
    fork_v = 1; fork_a = 16'h0301; stop_v = 1; ctx = "R4 bypass"; cyc();
    do_stop();
    ctx = "R7 post to running frame";
    do_post(2, 16'h0202);
    ctx = "R8 busy swap denied, R12 fork ignored";
    swap_r = 1; fork_v = 1; fork_a = 16'h0BAD; stop_v = 1; cyc();
    ctx = "R5 drain to exit";
    do_stop(); do_stop(); do_stop(); do_stop();
    do_swap();                         // frame 1
    do_stop(); do_stop();
    ctx = "R10 idle keeps frame";
    do_swap();
    do_stop();
    ctx = "R11 overflow";
    do_act(5, 16'hE005);
    for (int i = 0; i < 16; i++) do_post(5, 16'h0500 + i);
    do_post(6, 16'h0600);
    do_swap();                         // frame 5
    fork_v = 1; fork_a = 16'h0700; post_v = 1; post_f = 5; post_a = 16'h0701; cyc();
    do_stop(); do_stop();
    ctx = "random mix";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) begin
        act_v = 1; act_f = FW'($urandom_range(0, NF - 1)); act_a = AW'(16'hE000 + r);
      end else begin
        swap_r = ($urandom_range(0, 7) == 0);
        fork_v = ($urandom_range(0, 2) == 0); fork_a = AW'($urandom);
        stop_v = ($urandom_range(0, 1) == 0);
        post_v = ($urandom_range(0, 3) == 0);
        post_f = FW'($urandom_range(0, NF - 1)); post_a = AW'($urandom);
      end
      cyc();
    end
    summary();
  end
endmodule